// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a memory that two ports, left and right, share. Every clock it compares the enables and addresses of the two ports. When both are enabled on the same location it decides which port owns that location. It raises an active-low busy flag toward the other port and blocks that port's write strobe. Reads need no gating, because a read cannot corrupt the location. The memory array is not part of the block. The block only produces the qualified write strobes the array should use.

A mode input selects one of two roles. As master, the instance arbitrates on its own and drives its busy outputs. As slave, it does no arbitration of its own. It takes busy indications from an external master through two active-low inputs and uses them to block writes. Several instances can therefore share one arbitration decision when memories are placed side by side to widen the data word.

Top module: `dp_collide_arb`

## Requirements
- R1: While reset is high, and on the first cycle after it, both busy outputs read 1 (deasserted) and no port owns a location.
- R2: Busy outputs are active low and registered: the input values present at a clock edge decide the busy levels that appear just after that edge.
- R3: A collision exists only when both enables are 1 and the two addresses are equal. After the first edge at which no collision exists, both busy outputs read 1.
- R4: In master mode, if the two ports reach a common address at the same edge, the left port wins and the right busy output goes to 0.
- R5: In master mode, a port is "settled" when it was enabled at the same address on the previous edge. If exactly one port is settled when a new collision starts, that port wins and the other port's busy output goes to 0.
- R6: While a collision persists in master mode, ownership does not change, and neither busy output changes.
- R7: In master mode, a port's qualified write equals its write enable AND its chip enable, except that it is 0 whenever that port loses the collision that the current inputs create or continue. This gating takes effect in the same cycle, combinationally.
- R8: In slave mode (mode input 0), the block keeps no ownership, and both busy outputs read 1 after the next edge. A port's qualified write equals write enable AND chip enable AND its active-low busy input.
- R9: The two busy outputs never read 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_master | input | 1 | 1: arbitrate locally; 0: take busy from external inputs |
| l_addr | input | AW | Left port address |
| l_en | input | 1 | Left port chip enable, active high |
| l_we | input | 1 | Left port write enable, active high |
| r_addr | input | AW | Right port address |
| r_en | input | 1 | Right port chip enable, active high |
| r_we | input | 1 | Right port write enable, active high |
| l_busy_in_n | input | 1 | External busy for the left port in slave mode, active low |
| r_busy_in_n | input | 1 | External busy for the right port in slave mode, active low |
| l_busy_n | output | 1 | Left port busy, active low, registered |
| r_busy_n | output | 1 | Right port busy, active low, registered |
| l_wr_ok | output | 1 | Qualified write strobe for the left port |
| r_wr_ok | output | 1 | Qualified write strobe for the right port |

## Verification
The assertions check four properties on every cycle: the two busy flags are never low together, busy is released after any cycle without a collision, busy levels hold steady for as long as a collision lasts, and a busy port never gets a write through in either mode. The bench's directed scenarios are what show who actually wins. They cover the left-wins rule for simultaneous arrival, the later-arrival rule in both directions, and that the winner's writes still pass. A long stretch of mixed traffic over a small address range, with the mode toggling, compares busy flags and write strobes against a behavioural model on every clock.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_t;

  localparam int NPORT = 2;
  localparam int PL = 0;
  localparam int PR = 1;
endpackage

// File: rtl/dpc_track.sv
// Per-port history: flags a port that keeps the same enabled address
// across consecutive edges ("settled").
module dpc_track #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic          settled
);
  logic          en_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en;
      addr_q <= addr;
    end
  end

  assign settled = en && en_q && (addr == addr_q);
endmodule

// File: rtl/dpc_owner.sv
// Ownership state: who holds the contested location.
module dpc_owner
  import dpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             is_master,
  input  logic             hit,
  input  logic [NPORT-1:0] settled,
  output owner_t           own_q,
  output owner_t           own_nx
);
  always_comb begin
    own_nx = OWN_NONE;
    if (is_master && hit) begin
      if (own_q != OWN_NONE)
        own_nx = own_q;
      else if (settled[PR] && !settled[PL])
        own_nx = OWN_RIGHT;
      else
        own_nx = OWN_LEFT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) own_q <= OWN_NONE;
    else     own_q <= own_nx;
  end
endmodule

// File: rtl/dpc_wgate.sv
// Write qualification for each port.
module dpc_wgate #(
  parameter int NP = 2
) (
  input  logic          is_master,
  input  logic [NP-1:0] we,
  input  logic [NP-1:0] en,
  input  logic [NP-1:0] lose_nx,
  input  logic [NP-1:0] ext_busy_n,
  output logic [NP-1:0] wr_ok
);
  for (genvar i = 0; i < NP; i++) begin : g_port
    always_comb begin
      if (is_master) wr_ok[i] = we[i] & en[i] & ~lose_nx[i];
      else           wr_ok[i] = we[i] & en[i] & ext_busy_n[i];
    end
  end
endmodule

// File: rtl/dp_collide_arb.sv
module dp_collide_arb
  import dpc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_master,
  input  logic [AW-1:0] l_addr,
  input  logic          l_en,
  input  logic          l_we,
  input  logic [AW-1:0] r_addr,
  input  logic          r_en,
  input  logic          r_we,
  input  logic          l_busy_in_n,
  input  logic          r_busy_in_n,
  output logic          l_busy_n,
  output logic          r_busy_n,
  output logic          l_wr_ok,
  output logic          r_wr_ok
);
  logic [AW-1:0]    addr_a [NPORT];
  logic [NPORT-1:0] en_v, we_v, settled, lose_nx, ext_n, wr_v;
  logic             hit;
  owner_t           own_q, own_nx;

  assign addr_a[PL] = l_addr;
  assign addr_a[PR] = r_addr;
  assign en_v  = {r_en, l_en};
  assign we_v  = {r_we, l_we};
  assign ext_n = {r_busy_in_n, l_busy_in_n};

  for (genvar p = 0; p < NPORT; p++) begin : g_trk
    dpc_track #(.AW(AW)) u_trk (
      .clk(clk), .rst(rst), .en(en_v[p]), .addr(addr_a[p]), .settled(settled[p])
    );
  end

  assign hit = l_en && r_en && (l_addr == r_addr);

  dpc_owner u_own (
    .clk(clk), .rst(rst), .is_master(mode_master), .hit(hit),
    .settled(settled), .own_q(own_q), .own_nx(own_nx)
  );

  assign lose_nx[PL] = (own_nx == OWN_RIGHT);
  assign lose_nx[PR] = (own_nx == OWN_LEFT);

  dpc_wgate #(.NP(NPORT)) u_wg (
    .is_master(mode_master), .we(we_v), .en(en_v), .lose_nx(lose_nx),
    .ext_busy_n(ext_n), .wr_ok(wr_v)
  );

  assign l_wr_ok  = wr_v[PL];
  assign r_wr_ok  = wr_v[PR];
  assign l_busy_n = (own_q != OWN_RIGHT);
  assign r_busy_n = (own_q != OWN_LEFT);

  // ---------------- assertions ----------------
  assert_one_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (l_busy_n || r_busy_n));

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (l_busy_n && r_busy_n));

  assert_release_R3: assert property (@(posedge clk) disable iff (rst)
    !hit |=> (l_busy_n && r_busy_n));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_master && hit && !(l_busy_n && r_busy_n)) |=> ($stable(l_busy_n) && $stable(r_busy_n)));

  assert_gate_left_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_master && hit && !l_busy_n) |-> !l_wr_ok);

  assert_gate_right_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_master && hit && !r_busy_n) |-> !r_wr_ok);

  assert_slave_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (!mode_master && (!l_busy_in_n || !r_busy_in_n)) |->
      ((l_busy_in_n || !l_wr_ok) && (r_busy_in_n || !r_wr_ok)));
endmodule

// File: tb/sim_dp_collide_arb.sv
module sim_dp_collide_arb;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_master = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_en = 0, l_we = 0, r_en = 0, r_we = 0;
  logic l_busy_in_n = 1, r_busy_in_n = 1;
  logic l_busy_n, r_busy_n, l_wr_ok, r_wr_ok;

  always #4 clk = ~clk;

  dp_collide_arb #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .mode_master(mode_master),
    .l_addr(l_addr), .l_en(l_en), .l_we(l_we),
    .r_addr(r_addr), .r_en(r_en), .r_we(r_we),
    .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
    .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
  );

  int vectors = 0;
  int errors  = 0;
  // model state: owner 0 none, 1 left, 2 right
  int own = 0;
  int pl_en = 0, pr_en = 0;
  int pl_a = 0, pr_a = 0;

  task automatic chk(input string tag, input string sig, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, sig, act, exp, $time);
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  // one clock: drive at negedge, check strobes, then check busy after the edge
  task automatic step(input bit m, input int la, input bit le, input bit lw,
                      input int ra, input bit re, input bit rw,
                      input bit lb, input bit rb, input string tag);
    int nx;
    bit hitm, lst, rsd, ewl, ewr;
    @(negedge clk);
    mode_master = m; l_addr = AW'(la); l_en = le; l_we = lw;
    r_addr = AW'(ra); r_en = re; r_we = rw; l_busy_in_n = lb; r_busy_in_n = rb;
    #1;
    hitm = le && re && (la == ra);
    lst  = le && (pl_en != 0) && (la == pl_a);
    rsd  = re && (pr_en != 0) && (ra == pr_a);
    if (!m || !hitm) nx = 0;
    else if (own != 0) nx = own;
    else if (rsd && !lst) nx = 2;
    else nx = 1;
    if (m) begin ewl = lw && le && (nx != 2); ewr = rw && re && (nx != 1); end
    else   begin ewl = lw && le && lb;        ewr = rw && re && rb;        end
    chk(tag, "l_wr_ok", int'(l_wr_ok), int'(ewl));
    chk(tag, "r_wr_ok", int'(r_wr_ok), int'(ewr));
    @(posedge clk);
    own = nx; pl_en = le; pr_en = re; pl_a = la; pr_a = ra;
    #1;
    chk(tag, "l_busy_n", int'(l_busy_n), (own == 2) ? 0 : 1);
    chk(tag, "r_busy_n", int'(r_busy_n), (own == 1) ? 0 : 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "l_busy_n", int'(l_busy_n), 1);
    chk("R1", "r_busy_n", int'(r_busy_n), 1);
    rst = 1'b0;
    // R1: idle right after reset
    step(1, 0, 0, 0, 0, 0, 0, 1, 1, "R1");
    // R3: different addresses, then same address with one port disabled
    step(1, 3, 1, 1, 4, 1, 1, 1, 1, "R3");
    step(1, 4, 1, 1, 4, 0, 1, 1, 1, "R3");
    step(1, 4, 0, 1, 4, 1, 1, 1, 1, "R3");
    // R4: both jump onto 5 together -> left wins; R2 busy visible after edge
    step(1, 5, 1, 1, 5, 1, 1, 1, 1, "R4");
    // R6/R7: hold ownership, winner writes, loser blocked, loser reads ok
    step(1, 5, 1, 1, 5, 1, 1, 1, 1, "R6");
    step(1, 5, 1, 0, 5, 1, 0, 1, 1, "R7");
    step(1, 5, 1, 1, 5, 1, 1, 1, 1, "R7");
    // R3: right leaves -> busy released
    step(1, 5, 1, 1, 6, 1, 1, 1, 1, "R3");
    // R5: left settled at 9, right arrives later -> right busy
    step(1, 9, 1, 0, 6, 1, 0, 1, 1, "R5");
    step(1, 9, 1, 1, 9, 1, 1, 1, 1, "R5");
    step(1, 9, 1, 1, 9, 1, 1, 1, 1, "R6");
    step(1, 1, 0, 0, 12, 1, 0, 1, 1, "R3");
    // R5: right settled at 12, left arrives later -> left busy
    step(1, 12, 1, 1, 12, 1, 1, 1, 1, "R5");
    step(1, 12, 1, 1, 12, 1, 1, 1, 1, "R7");
    // R8: slave mode clears busy, gates by external inputs
    step(0, 12, 1, 1, 12, 1, 1, 1, 1, "R8");
    step(0, 12, 1, 1, 12, 1, 1, 0, 1, "R8");
    step(0, 12, 1, 1, 12, 1, 1, 1, 0, "R8");
    step(0, 7, 1, 1, 8, 1, 1, 0, 0, "R8");
    // R9/R2: mixed traffic, small address range, mode toggling
    for (int i = 0; i < 400; i++) begin
      step((($urandom_range(0, 7)) != 0),
           int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
           int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), "R9");
    end
    summary();
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end
endmodule